// File: doc/BRIEF.md
# Three-Wire Synthesizer Control Port

This block is the programming port of a frequency synthesizer. A host shifts a 19-bit word in, most significant bit first, one bit on each rising edge of a serial clock. It then raises a latch-enable line. Bit 0 of the word is a routing flag. It decides whether the rest of the word goes to the reference-divider holding register or to the main-divider holding register. The register that is not chosen keeps its value.

The reference register holds a 14-bit reference ratio and four mode bits: prescaler ratio select, phase-comparator polarity, lock-output source select and charge-pump current select. The main register holds a 7-bit swallow count and an 11-bit main count. The divider chain reads these fields from parallel outputs. The block also checks the values it holds and raises flags when a latched ratio is below 3, or when the swallow count is not below the main count. A status output stays high until both registers have been written at least once.

The shift register runs on the serial clock. The latch-enable line passes through a synchronizer into the system clock domain, and the holding registers are loaded on its rising edge there.

Top module: `serialCtlPort`

## Requirements
- R1: Serial bits are taken on rising edges of `serClk`, most significant bit first, so the last bit shifted before a latch becomes bit 0 of the word.
- R2: A latch with word bit 0 = 1 loads the reference register. The fields are taken from these word bits: 14:1 to `refRatio`, 15 to `prescSel`, 16 to `pdPolarity`, 17 to `lockOutSel` and 18 to `cpCurrentSel`.
- R3: A latch with word bit 0 = 0 loads the main register. Word bits 7:1 go to `swallowCnt` and bits 18:8 go to `mainCnt`.
- R4: A latch leaves the register that was not selected unchanged.
- R5: Shifting bits while `serLe` stays low changes no output.
- R6: After `serLe` rises, the new values appear on the outputs by the fourth rising edge of `sysClk`.
- R7: After reset, all field outputs are 0, both error flags are 0 and `notConfigured` is 1.
- R8: `notConfigured` falls only once both registers have been loaded at least once, and it never rises again until reset.
- R9: `refRangeErr` is 1 exactly when the reference register has been loaded and `refRatio` is below 3.
- R10: `mainRangeErr` is 1 exactly when the main register has been loaded and either `mainCnt` is below 3 or `swallowCnt` is greater than or equal to `mainCnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock for the latch logic and the holding registers |
| rstN | input | 1 | Asynchronous reset, active low |
| serClk | input | 1 | Serial shift clock |
| serData | input | 1 | Serial data, most significant bit first |
| serLe | input | 1 | Latch enable; a rising edge transfers the shifted word |
| refRatio | output | 14 | Reference divider ratio |
| prescSel | output | 1 | Prescaler ratio select |
| pdPolarity | output | 1 | Phase-comparator polarity |
| lockOutSel | output | 1 | Lock-output source select |
| cpCurrentSel | output | 1 | Charge-pump current select |
| swallowCnt | output | 7 | Swallow count |
| mainCnt | output | 11 | Main divider count |
| refRangeErr | output | 1 | Reference ratio is out of range |
| mainRangeErr | output | 1 | Main or swallow count is out of range |
| notConfigured | output | 1 | High until both registers have been written |

## Verification
The bench builds the block with its default parameters: a 14-bit reference ratio, a 7-bit swallow count, an 11-bit main count and a two-stage latch synchronizer. With these values the full 19-bit word and both routings are covered. The ratio boundary at 2 and 3 is reachable, and so are the full-scale values 16383, 127 and 2047. The swallow count can also be set equal to, just above and just below the main count. With the two-stage synchronizer, the latency of R6 can be checked against a fixed four-cycle window.

// File: rtl/ctlPortPkg.sv
package ctlPortPkg;

  // Strobes the control sends to the datapath, one system cycle wide.
  typedef struct packed {
    logic loadRef;
    logic loadMain;
  } ctlStrobeT;

endpackage

// File: rtl/ctlPortControl.sv
module ctlPortControl
  import ctlPortPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      sysClk,
  input  logic      rstN,
  input  logic      serLe,
  input  logic      routeBit,
  output ctlStrobeT strobe,
  output logic      refWritten,
  output logic      mainWritten,
  output logic      notConfigured
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] leChain;
  logic          lePrev;
  logic          leRise;

  // Synchronizer chain for the latch enable.
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge sysClk or negedge rstN) begin
          if (!rstN) leChain[0] <= 1'b0;
          else       leChain[0] <= serLe;
        end
      end else begin : gRest
        always_ff @(posedge sysClk or negedge rstN) begin
          if (!rstN) leChain[g] <= 1'b0;
          else       leChain[g] <= leChain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) lePrev <= 1'b0;
    else       lePrev <= leChain[LAST];
  end

  assign leRise = leChain[LAST] & ~lePrev;

  always_comb begin
    strobe.loadRef  = leRise &  routeBit;
    strobe.loadMain = leRise & ~routeBit;
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      refWritten  <= 1'b0;
      mainWritten <= 1'b0;
    end else begin
      if (strobe.loadRef)  refWritten  <= 1'b1;
      if (strobe.loadMain) mainWritten <= 1'b1;
    end
  end

  assign notConfigured = ~(refWritten & mainWritten);

  AST_STROBE_PULSE: assert property (@(posedge sysClk) disable iff (!rstN)
    (strobe.loadRef | strobe.loadMain) |=> !(strobe.loadRef | strobe.loadMain)); // R6
  AST_REF_STICKY: assert property (@(posedge sysClk) disable iff (!rstN)
    refWritten |=> refWritten); // R8
  AST_MAIN_STICKY: assert property (@(posedge sysClk) disable iff (!rstN)
    mainWritten |=> mainWritten); // R8
  AST_CFG_NEEDS_LOAD: assert property (@(posedge sysClk) disable iff (!rstN)
    $fell(notConfigured) |-> $past(strobe.loadRef | strobe.loadMain)); // R8

endmodule

// File: rtl/ctlPortDatapath.sv
module ctlPortDatapath
  import ctlPortPkg::*;
#(
  parameter int REF_W     = 14,
  parameter int MODE_W    = 4,
  parameter int SWAL_W    = 7,
  parameter int MAIN_W    = 11,
  parameter int MIN_RATIO = 3,
  parameter int WORD_W    = 19
) (
  input  logic              sysClk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  ctlStrobeT         strobe,
  input  logic              refWritten,
  input  logic              mainWritten,
  output logic              routeBit,
  output logic [REF_W-1:0]  refRatio,
  output logic [MODE_W-1:0] modeBits,
  output logic [SWAL_W-1:0] swallowCnt,
  output logic [MAIN_W-1:0] mainCnt,
  output logic              refRangeErr,
  output logic              mainRangeErr
);

  localparam logic [REF_W-1:0]  REF_MIN  = REF_W'(MIN_RATIO);
  localparam logic [MAIN_W-1:0] MAIN_MIN = MAIN_W'(MIN_RATIO);
  localparam int MODE_LO = 1 + REF_W;
  localparam int MAIN_LO = 1 + SWAL_W;

  logic [WORD_W-1:0] shiftReg;

  // Serial shift, MSB first: new bits enter at bit 0.
  always_ff @(posedge serClk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else       shiftReg <= {shiftReg[WORD_W-2:0], serData};
  end

  assign routeBit = shiftReg[0];

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      refRatio <= '0;
      modeBits <= '0;
    end else if (strobe.loadRef) begin
      refRatio <= shiftReg[REF_W:1];
      modeBits <= shiftReg[MODE_LO+MODE_W-1:MODE_LO];
    end
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      swallowCnt <= '0;
      mainCnt    <= '0;
    end else if (strobe.loadMain) begin
      swallowCnt <= shiftReg[SWAL_W:1];
      mainCnt    <= shiftReg[MAIN_LO+MAIN_W-1:MAIN_LO];
    end
  end

  logic [MAIN_W-1:0] swallowWide;
  assign swallowWide = MAIN_W'(swallowCnt);

  always_comb begin
    refRangeErr  = refWritten & (refRatio < REF_MIN);
    mainRangeErr = mainWritten & ((mainCnt < MAIN_MIN) | (swallowWide >= mainCnt));
  end

  AST_REF_HOLD: assert property (@(posedge sysClk) disable iff (!rstN)
    !strobe.loadRef |=> ($stable(refRatio) && $stable(modeBits))); // R4
  AST_MAIN_HOLD: assert property (@(posedge sysClk) disable iff (!rstN)
    !strobe.loadMain |=> ($stable(swallowCnt) && $stable(mainCnt))); // R4
  AST_REF_ERR_GATED: assert property (@(posedge sysClk) disable iff (!rstN)
    !refWritten |-> !refRangeErr); // R9
  AST_MAIN_ERR_GATED: assert property (@(posedge sysClk) disable iff (!rstN)
    !mainWritten |-> !mainRangeErr); // R10

endmodule

// File: rtl/serialCtlPort.sv
module serialCtlPort
  import ctlPortPkg::*;
#(
  parameter int REF_W       = 14,
  parameter int SWAL_W      = 7,
  parameter int MAIN_W      = 11,
  parameter int MIN_RATIO   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              sysClk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              serLe,
  output logic [REF_W-1:0]  refRatio,
  output logic              prescSel,
  output logic              pdPolarity,
  output logic              lockOutSel,
  output logic              cpCurrentSel,
  output logic [SWAL_W-1:0] swallowCnt,
  output logic [MAIN_W-1:0] mainCnt,
  output logic              refRangeErr,
  output logic              mainRangeErr,
  output logic              notConfigured
);

  localparam int MODE_W  = 4;
  localparam int REF_LEN = REF_W + MODE_W;
  localparam int MN_LEN  = SWAL_W + MAIN_W;
  localparam int WORD_W  = 1 + ((REF_LEN > MN_LEN) ? REF_LEN : MN_LEN);

  ctlStrobeT         strobe;
  logic              routeBit;
  logic              refWritten;
  logic              mainWritten;
  logic [MODE_W-1:0] modeBits;

  ctlPortControl #(.SYNC_STAGES(SYNC_STAGES)) uCtl (
    .sysClk       (sysClk),
    .rstN         (rstN),
    .serLe        (serLe),
    .routeBit     (routeBit),
    .strobe       (strobe),
    .refWritten   (refWritten),
    .mainWritten  (mainWritten),
    .notConfigured(notConfigured)
  );

  ctlPortDatapath #(
    .REF_W    (REF_W),
    .MODE_W   (MODE_W),
    .SWAL_W   (SWAL_W),
    .MAIN_W   (MAIN_W),
    .MIN_RATIO(MIN_RATIO),
    .WORD_W   (WORD_W)
  ) uDp (
    .sysClk      (sysClk),
    .rstN        (rstN),
    .serClk      (serClk),
    .serData     (serData),
    .strobe      (strobe),
    .refWritten  (refWritten),
    .mainWritten (mainWritten),
    .routeBit    (routeBit),
    .refRatio    (refRatio),
    .modeBits    (modeBits),
    .swallowCnt  (swallowCnt),
    .mainCnt     (mainCnt),
    .refRangeErr (refRangeErr),
    .mainRangeErr(mainRangeErr)
  );

  // Mode bit order inside the word: prescaler, polarity, lock source, current.
  assign prescSel     = modeBits[0];
  assign pdPolarity   = modeBits[1];
  assign lockOutSel   = modeBits[2];
  assign cpCurrentSel = modeBits[3];

endmodule

// File: tb/serialCtlPort_test.sv
module serialCtlPort_test;

  logic        sysClk = 1'b0;
  logic        rstN = 1'b0;
  logic        serClk = 1'b0;
  logic        serData = 1'b0;
  logic        serLe = 1'b0;
  logic [13:0] refRatio;
  logic        prescSel, pdPolarity, lockOutSel, cpCurrentSel;
  logic [6:0]  swallowCnt;
  logic [10:0] mainCnt;
  logic        refRangeErr, mainRangeErr, notConfigured;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [13:0] eRatio = '0;
  logic [3:0]  eMode = '0;
  logic [6:0]  eA = '0;
  logic [10:0] eN = '0;
  bit          eRefW = 0;
  bit          eMainW = 0;

  always #5 sysClk = ~sysClk;

  serialCtlPort uut (
    .sysClk(sysClk), .rstN(rstN), .serClk(serClk), .serData(serData), .serLe(serLe),
    .refRatio(refRatio), .prescSel(prescSel), .pdPolarity(pdPolarity),
    .lockOutSel(lockOutSel), .cpCurrentSel(cpCurrentSel), .swallowCnt(swallowCnt),
    .mainCnt(mainCnt), .refRangeErr(refRangeErr), .mainRangeErr(mainRangeErr),
    .notConfigured(notConfigured)
  );

  function automatic bit expRefErr();
    return eRefW && (eRatio < 14'd3);
  endfunction

  function automatic bit expMainErr();
    return eMainW && ((eN < 11'd3) || ({4'd0, eA} >= eN));
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    check(req, "refRatio", int'(refRatio), int'(eRatio));
    check(req, "modeBits", int'({cpCurrentSel, lockOutSel, pdPolarity, prescSel}), int'(eMode));
    check(req, "swallowCnt", int'(swallowCnt), int'(eA));
    check(req, "mainCnt", int'(mainCnt), int'(eN));
    check("R9", "refRangeErr", int'(refRangeErr), int'(expRefErr()));
    check("R10", "mainRangeErr", int'(mainRangeErr), int'(expMainErr()));
    check("R8", "notConfigured", int'(notConfigured), int'(!(eRefW && eMainW)));
  endtask

  // R1: MSB first, one bit per serClk rising edge.
  task automatic shiftWord(input logic [18:0] w);
    for (int i = 18; i >= 0; i--) begin
      serData = w[i];
      #7 serClk = 1'b1;
      #7 serClk = 1'b0;
    end
  endtask

  task automatic latch();
    @(negedge sysClk) serLe = 1'b1;
    repeat (4) @(negedge sysClk);
    serLe = 1'b0;
  endtask

  task automatic sendRef(input logic [13:0] r, input logic [3:0] m, input string req);
    shiftWord({m, r, 1'b1});
    latch();
    eRatio = r; eMode = m; eRefW = 1;
    checkAll(req);                       // R2, R6
    repeat (4) @(negedge sysClk);
  endtask

  task automatic sendMain(input logic [6:0] a, input logic [10:0] n, input string req);
    shiftWord({n, a, 1'b0});
    latch();
    eA = a; eN = n; eMainW = 1;
    checkAll(req);                       // R3, R6
    repeat (4) @(negedge sysClk);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge sysClk);
    checkAll("R7");
    check("R7", "notConfigured", int'(notConfigured), 1);
    rstN = 1'b1;
    repeat (2) @(negedge sysClk);

    // Only the reference register written: still not configured.
    sendRef(14'd3, 4'b0101, "R2");
    check("R8", "notConfigured after ref only", int'(notConfigured), 1);
    sendRef(14'd2, 4'b1010, "R9");
    sendMain(7'd5, 11'd5, "R10");        // A == N
    check("R8", "notConfigured after both", int'(notConfigured), 0);
    sendMain(7'd6, 11'd5, "R10");        // A > N
    sendMain(7'd2, 11'd3, "R10");        // lowest legal pair
    sendMain(7'd0, 11'd2, "R10");        // N below range
    sendMain(7'd127, 11'd2047, "R3");
    sendRef(14'd16383, 4'b1111, "R4");   // main fields must stay
    sendRef(14'd0, 4'b0000, "R9");

    // R5: shift with LE low, nothing changes.
    shiftWord(19'h5AAA5);
    repeat (4) @(negedge sysClk);
    checkAll("R5");
    shiftWord(19'h2AAAA);
    repeat (4) @(negedge sysClk);
    checkAll("R5");

    for (int k = 0; k < 40; k++) begin
      logic [31:0] r = $urandom;
      if (r[0]) sendRef(r[14:1], r[18:15], "R4");
      else      sendMain(r[7:1], (r[20]) ? r[18:8] : 11'(r[10:8]), "R4");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge sysClk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule